// File: doc/BRIEF.md
# ALU Extra-Move Expansion Sequencer

This block sits in the issue stage of a small microcontroller. It accepts one decoded ALU instruction that carries a two-bit extra-move count. It turns that instruction into a short stream of micro-operations. The ALU operation always goes out first. Up to three register-to-register moves follow it, and each move copies the second-source register into a target register.

The number of moves is the requested count, limited by a remaining-count value that is sampled when the instruction is accepted. The target of each move depends on two things:

- If the instruction's destination is one of the special registers (index 0x1d, 0x1e or 0x1f), moves go to the data port register 0x1d. In the three-move case, the middle move instead writes the instruction's own destination.
- If the destination is an ordinary register, every move is sent to the always-zero register 0x00, where it has no effect.

The sequencer does not depend on any loop prefix. It presents one micro-op per cycle on a valid/ready port and holds it while the consumer stalls.

Top module: `xmove_sequencer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The cycle after an instruction is accepted (`in_valid` and `in_ready` both high at a clock edge), `out_valid` is 1 and the micro-op shown is the ALU op: `out_is_mov`=0, `out_dst`=the instruction's dst, `out_src`=the instruction's src2.
- R3: The number of moves is M = min(N, rem). The expansion has exactly M+1 micro-ops, and `out_last`=1 only on the final one.
- R4: When N=0 or rem=0, only the ALU micro-op is emitted, with `out_last`=1.
- R5: With a special dst and M equal to 1 or 2, every move has `out_is_mov`=1, `out_dst`=0x1d and `out_src`=src2.
- R6: With a special dst and M=3, moves one and three write 0x1d and move two writes dst. All three read src2.
- R7: With dst below 0x1d, every move has `out_dst`=0x00 and reads src2.
- R8: While `out_valid` is 1 and `out_ready` is 0, the micro-op on the output stays unchanged in the next cycle.
- R9: `in_ready` is 0 from the cycle after acceptance until the last micro-op is taken. In the following cycle, `in_ready` is 1 and `out_valid` is 0.
- R10: Once a non-final micro-op is taken, the next one is valid in the very next cycle (no bubbles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_xmov | input | 2 | Requested extra-move count N |
| in_dst | input | 5 | Instruction destination index |
| in_src2 | input | 5 | Instruction second-source index |
| in_rem | input | 8 | Remaining-count value |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_is_mov | output | 1 | 0 = ALU op, 1 = move |
| out_dst | output | 5 | Micro-op destination index |
| out_src | output | 5 | Micro-op source index |
| out_last | output | 1 | Final micro-op of the expansion |

## Verification
The bench sweeps every count N against remaining-count values around the clamp point (0 to 4 and 255). It pairs these with ordinary destinations, the boundary index 0x1c and all three special destinations. Each sweep runs with a free-flowing consumer and again with a stall on every micro-op.

The checks catch the typical faults:
- A clamp that uses max instead of min, or ignores rem, gives the wrong micro-op count and a misplaced last flag.
- Routing the middle move wrongly shows up as a wrong destination in the three-move case.
- A below-special comparison that is off by one misroutes destination 0x1c or 0x1d.
- Advancing during a stall skips a micro-op.
- Releasing `in_ready` early is seen before the final micro-op.

// File: rtl/xmv_pkg.sv
package xmv_pkg;
  typedef enum logic {
    UOP_ALU = 1'b0,
    UOP_MOV = 1'b1
  } uop_kind_e;

  localparam int unsigned REG_W_DEF = 5;
  localparam int unsigned CNT_W_DEF = 2;
  localparam int unsigned REM_W_DEF = 8;
endpackage

// File: rtl/xmv_clamp.sv
module xmv_clamp #(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned REM_W = 8
) (
  input  logic [CNT_W-1:0] req,
  input  logic [REM_W-1:0] rem,
  output logic [CNT_W-1:0] cnt
);
  localparam int unsigned CW = (CNT_W > REM_W) ? CNT_W : REM_W;

  function automatic logic [CNT_W-1:0] clamp_min(input logic [CNT_W-1:0] n,
                                                 input logic [REM_W-1:0] r);
    logic [CW-1:0] nw;
    logic [CW-1:0] rw;
    nw = CW'(n);
    rw = CW'(r);
    return (rw < nw) ? CNT_W'(rw) : n;
  endfunction

  assign cnt = clamp_min(req, rem);
endmodule

// File: rtl/xmv_ctrl.sv
module xmv_ctrl #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             busy,
  output logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             accept,
  output logic             take,
  output logic             final_take
);
  assign accept     = in_valid && !busy;
  assign take       = busy && out_ready;
  assign final_take = take && (step == cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      step  <= '0;
      cnt_q <= cnt_in;
    end else if (final_take) begin
      busy  <= 1'b0;
    end else if (take) begin
      step  <= step + 1'b1;
    end
  end
endmodule

// File: rtl/xmv_route.sv
module xmv_route
  import xmv_pkg::*;
#(
  parameter int unsigned REG_W        = 5,
  parameter int unsigned CNT_W        = 2,
  parameter logic [REG_W-1:0] SPECIAL_BASE = 5'h1d,
  parameter logic [REG_W-1:0] DATA_REG     = 5'h1d,
  parameter logic [REG_W-1:0] ZERO_REG     = 5'h00
) (
  input  logic [CNT_W-1:0] step,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src2,
  output uop_kind_e        kind,
  output logic [REG_W-1:0] udst,
  output logic [REG_W-1:0] usrc,
  output logic             last
);
  localparam logic [CNT_W-1:0] THREE  = CNT_W'(3);
  localparam logic [CNT_W-1:0] MIDDLE = CNT_W'(2);

  function automatic logic [REG_W-1:0] move_target(input logic [CNT_W-1:0] k,
                                                   input logic [CNT_W-1:0] m,
                                                   input logic [REG_W-1:0] d);
    if (d < SPECIAL_BASE)            return ZERO_REG;
    else if (m == THREE && k == MIDDLE) return d;
    else                             return DATA_REG;
  endfunction

  always_comb begin
    usrc = src2;
    last = (step == cnt);
    if (step == '0) begin
      kind = UOP_ALU;
      udst = dst;
    end else begin
      kind = UOP_MOV;
      udst = move_target(step, cnt, dst);
    end
  end
endmodule

// File: rtl/xmove_sequencer.sv
module xmove_sequencer
  import xmv_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned REM_W = 8,
  parameter logic [REG_W-1:0] SPECIAL_BASE = 5'h1d,
  parameter logic [REG_W-1:0] DATA_REG     = 5'h1d,
  parameter logic [REG_W-1:0] ZERO_REG     = 5'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_xmov,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src2,
  input  logic [REM_W-1:0] in_rem,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_is_mov,
  output logic [REG_W-1:0] out_dst,
  output logic [REG_W-1:0] out_src,
  output logic             out_last
);
  // named events for the checker
  logic             accept_w;
  logic             take_w;
  logic             final_take_w;
  logic             busy_w;
  logic [CNT_W-1:0] step_w;
  logic [CNT_W-1:0] cnt_q_w;
  logic [CNT_W-1:0] clamped_w;

  logic [REG_W-1:0] dst_q;
  logic [REG_W-1:0] src2_q;
  uop_kind_e        kind_w;

  xmv_clamp #(.CNT_W(CNT_W), .REM_W(REM_W)) u_clamp (
    .req (in_xmov),
    .rem (in_rem),
    .cnt (clamped_w)
  );

  xmv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .cnt_in     (clamped_w),
    .busy       (busy_w),
    .step       (step_w),
    .cnt_q      (cnt_q_w),
    .accept     (accept_w),
    .take       (take_w),
    .final_take (final_take_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q  <= '0;
      src2_q <= '0;
    end else if (accept_w) begin
      dst_q  <= in_dst;
      src2_q <= in_src2;
    end
  end

  xmv_route #(
    .REG_W(REG_W), .CNT_W(CNT_W), .SPECIAL_BASE(SPECIAL_BASE),
    .DATA_REG(DATA_REG), .ZERO_REG(ZERO_REG)
  ) u_route (
    .step (step_w),
    .cnt  (cnt_q_w),
    .dst  (dst_q),
    .src2 (src2_q),
    .kind (kind_w),
    .udst (out_dst),
    .usrc (out_src),
    .last (out_last)
  );

  assign in_ready   = !busy_w;
  assign out_valid  = busy_w;
  assign out_is_mov = (kind_w == UOP_MOV);
endmodule

// File: rtl/xmove_sequencer_chk.sv
module xmove_sequencer_chk #(
  parameter int unsigned REG_W = 5,
  parameter logic [REG_W-1:0] SPECIAL_BASE = 5'h1d,
  parameter logic [REG_W-1:0] ZERO_REG     = 5'h00
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             take,
  input logic             final_take,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_is_mov,
  input logic [REG_W-1:0] out_dst,
  input logic [REG_W-1:0] out_src,
  input logic             out_last
);
  a_r2_alu_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && !out_is_mov);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_src)
                               && $stable(out_is_mov) && $stable(out_last));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  a_r9_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    final_take |=> in_ready && !out_valid);

  a_r10_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    take && !out_last |=> out_valid && out_is_mov);

  a_r7_move_target_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_mov |-> (out_dst == ZERO_REG) || (out_dst >= SPECIAL_BASE));
endmodule

bind xmove_sequencer xmove_sequencer_chk #(
  .REG_W(REG_W), .SPECIAL_BASE(SPECIAL_BASE), .ZERO_REG(ZERO_REG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept_w),
  .take       (take_w),
  .final_take (final_take_w),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_is_mov (out_is_mov),
  .out_dst    (out_dst),
  .out_src    (out_src),
  .out_last   (out_last)
);

// File: tb/xmove_sequencer_test.sv
module xmove_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_xmov = '0;
  logic [4:0] in_dst = '0;
  logic [4:0] in_src2 = '0;
  logic [7:0] in_rem = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_is_mov;
  logic [4:0] out_dst;
  logic [4:0] out_src;
  logic       out_last;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmove_sequencer uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_xmov(in_xmov), .in_dst(in_dst), .in_src2(in_src2), .in_rem(in_rem),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_is_mov(out_is_mov), .out_dst(out_dst), .out_src(out_src), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected micro-op packed as {is_mov, dst, src, last}
  function automatic logic [11:0] expect_uop(input int k, input int m,
                                             input logic [4:0] d, input logic [4:0] s);
    logic [4:0] t;
    if (k == 0) t = d;
    else if (d < 5'h1d) t = 5'h00;
    else if (m == 3 && k == 2) t = d;
    else t = 5'h1d;
    return {(k != 0), t, s, (k == m)};
  endfunction

  function automatic string tag_for(input int k, input int m, input logic [4:0] d);
    if (k == 0) return (m == 0) ? "R4" : "R2";
    if (d < 5'h1d) return "R7";
    if (m == 3) return "R6";
    return "R5";
  endfunction

  task automatic run_one(input int n, input int rem, input logic [4:0] d,
                         input logic [4:0] s, input bit stall);
    int m;
    int k;
    bit stalled;
    logic [11:0] got;
    logic [11:0] want;
    m = (rem < n) ? rem : n;
    @(negedge clk);
    check(in_ready == 1'b1, "R9", in_ready, 1);
    in_valid = 1'b1; in_xmov = 2'(n); in_rem = 8'(rem); in_dst = d; in_src2 = s;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    in_xmov = 2'(3 - n); in_rem = 8'(~rem); in_dst = ~d; in_src2 = ~s;
    k = 0;
    stalled = 1'b0;
    while (k <= m) begin
      out_ready = !(stall && !stalled);
      got  = {out_is_mov, out_dst, out_src, out_last};
      want = expect_uop(k, m, d, s);
      check(out_valid == 1'b1, (k == 0) ? "R2" : "R10", out_valid, 1);
      check(got[11:1] == want[11:1], tag_for(k, m, d), got, want);
      check(got[0] == want[0], "R3", got[0], want[0]);
      check(in_ready == 1'b0, "R9", in_ready, 0);
      if (out_ready) begin
        k++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1; // next pass re-checks the same micro-op (R8)
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R3", out_valid, 0);
    check(in_ready == 1'b1, "R9", in_ready, 1);
  endtask

  initial begin
    logic [4:0] dsts [6];
    int rems [6];
    dsts = '{5'h00, 5'h05, 5'h1c, 5'h1d, 5'h1e, 5'h1f};
    rems = '{0, 1, 2, 3, 4, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    for (int st = 0; st < 2; st++)
      for (int n = 0; n < 4; n++)
        for (int ri = 0; ri < 6; ri++)
          for (int di = 0; di < 6; di++)
            run_one(n, rems[ri], dsts[di], 5'(di * 7 + n + ri), st[0]);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule